// File: doc/BRIEF.md
# Cache Line Refill Controller with Early Processor Restart

This block handles a cache miss by fetching an entire line, one word at a time, from a slower next-level memory. The processor does not wait for the whole line. The word it asked for is handed back through a dedicated return port as soon as that word arrives. The controller then keeps collecting the rest of the line. When every word is present, it writes the full line to the cache array in a single cycle.

Each miss selects one of two fetch orders. In wrap-first order, the missed word is requested first and the line is requested in wrap-around order. In ascending order, the line is requested from word 0 upward, and the processor is released when its word comes back. The memory side uses separate valid/ready handshakes for requests and responses. Several requests may be in flight at once, and responses come back in request order with any latency.

Top module: `line_refill_ctrl`

## Requirements
- R1: After reset, `busy`, `mem_req_valid`, `mem_rsp_ready`, `cpu_valid` and `fill_valid` are all 0.
- R2: A miss presented while `busy` is 0 is accepted at that clock edge, and `busy` is 1 from the next cycle. A miss presented while `busy` is 1 is ignored: the line address and the offset in use do not change.
- R3: With `miss_wrap` = 1, the k-th request of a miss (k = 0..7) asks for word (offset + k) mod 8. The first request is therefore the missed word.
- R4: With `miss_wrap` = 0, the k-th request of a miss asks for word k.
- R5: `mem_req_addr` is the line address concatenated above a 3-bit word index in bits [2:0]. While `mem_req_valid` is 1 and `mem_req_ready` is 0, the request stays valid and its address is unchanged.
- R6: For each miss, `cpu_valid` is 1 for exactly one cycle. That cycle is the one after the response carrying the word at the requested offset is accepted, and `cpu_data` then equals that word.
- R7: In wrap-first mode, the processor is restarted one cycle after the first response, while the rest of the line is still being filled.
- R8: `fill_valid` is a one-cycle pulse, one cycle after the eighth response is accepted. `fill_data` bits [32i+31:32i] hold word i of the line, and `fill_line_addr` equals the miss line address.
- R9: `busy` is 0 in the cycle `fill_valid` is 1, and a new miss can be accepted in that cycle.
- R10: Exactly 8 requests are issued per miss. `mem_rsp_ready` is 1 exactly when the controller has more requests issued than responses accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Miss request strobe |
| miss_line | input | 20 | Line address of the miss |
| miss_offset | input | 3 | Word offset the processor wants |
| miss_wrap | input | 1 | 1 = wrap-first order, 0 = ascending order |
| busy | output | 1 | Refill in progress; misses ignored |
| mem_req_valid | output | 1 | Word request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 23 | {line address, word index} |
| mem_rsp_valid | input | 1 | Response word valid |
| mem_rsp_ready | output | 1 | Controller accepts the response |
| mem_rsp_data | input | 32 | Response word |
| cpu_valid | output | 1 | Requested word returned to processor |
| cpu_data | output | 32 | Requested word |
| fill_valid | output | 1 | Full line write to the cache array |
| fill_line_addr | output | 20 | Line address of the fill |
| fill_data | output | 256 | Assembled line, word i at bits [32i+31:32i] |

## Verification
The embedded properties check the following on every cycle: a stalled request holds its address, a miss during a refill leaves the captured miss unchanged, only one processor return occurs per miss, the return comes before or with the fill, and `busy` is clear during the fill pulse. Only the bench scenarios can show the full request order for both modes and every offset, and the correct forwarded data under random memory stalls. They also show the exact cycle of the restart relative to the response, and the contents of the assembled line. The scenarios include offset 0 and offset 7 in both modes, back-to-back misses, and miss strobes during a refill.

// File: rtl/refill_pkg.sv
package refill_pkg;
  typedef enum logic {
    ORDER_ASCENDING = 1'b0,
    ORDER_WRAPPED   = 1'b1
  } fetch_order_e;
endpackage

// File: rtl/refill_seq.sv
module refill_seq #(
  parameter int WORDS = 8,
  localparam int OW = $clog2(WORDS),
  localparam int CW = $clog2(WORDS + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [OW-1:0]            base_off,
  input  refill_pkg::fetch_order_e order,
  input  logic                     advance,
  output logic [CW-1:0]            beat,
  output logic [OW-1:0]            word_idx,
  output logic                     done
);
  logic [CW-1:0] beat_q;
  logic [OW-1:0] beat_low;

  always_ff @(posedge clk) begin
    if (rst) beat_q <= '0;
    else if (start) beat_q <= '0;
    else if (advance && !done) beat_q <= beat_q + CW'(1);
  end

  assign beat     = beat_q;
  assign done     = (beat_q == CW'(WORDS));
  assign beat_low = beat_q[OW-1:0];

  logic [OW-1:0] wrap_idx;
  generate
    if ((WORDS & (WORDS - 1)) == 0) begin : g_pow2
      assign wrap_idx = base_off + beat_low;
    end else begin : g_mod
      logic [OW:0] sum_w;
      assign sum_w    = {1'b0, base_off} + {1'b0, beat_low};
      assign wrap_idx = (sum_w >= (OW+1)'(WORDS)) ? OW'(sum_w - (OW+1)'(WORDS)) : sum_w[OW-1:0];
    end
  endgenerate

  assign word_idx = (order == refill_pkg::ORDER_WRAPPED) ? wrap_idx : beat_low;

  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    done |-> !(advance && !start) || $stable(beat_q)); // R10
endmodule

// File: rtl/refill_linebuf.sv
module refill_linebuf #(
  parameter int WORDS = 8,
  parameter int DW    = 32,
  localparam int OW   = $clog2(WORDS)
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic [OW-1:0]       wr_idx,
  input  logic [DW-1:0]       wr_data,
  output logic [WORDS*DW-1:0] line_out
);
  generate
    for (genvar i = 0; i < WORDS; i++) begin : g_word
      logic [DW-1:0] slot_q;
      always_ff @(posedge clk) begin
        if (wr_en && (wr_idx == OW'(i))) slot_q <= wr_data;
      end
      assign line_out[i*DW +: DW] = slot_q;
    end
  endgenerate
endmodule

// File: rtl/refill_fwd.sv
module refill_fwd #(
  parameter int WORDS = 8,
  parameter int DW    = 32,
  localparam int OW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          rsp_fire,
  input  logic [OW-1:0] rsp_idx,
  input  logic [OW-1:0] want_idx,
  input  logic [DW-1:0] rsp_data,
  output logic          cpu_valid,
  output logic [DW-1:0] cpu_data,
  output logic          fwd_done
);
  logic seen_q;
  logic hit;

  assign hit = rsp_fire && (rsp_idx == want_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_valid <= 1'b0;
      cpu_data  <= '0;
    end else begin
      cpu_valid <= hit;
      if (hit) cpu_data <= rsp_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) seen_q <= 1'b0;
    else if (cpu_valid) seen_q <= 1'b1;
  end

  assign fwd_done = seen_q;

  AST_SINGLE_RETURN: assert property (@(posedge clk) disable iff (rst)
    cpu_valid |-> !seen_q); // R6
endmodule

// File: rtl/line_refill_ctrl.sv
module line_refill_ctrl #(
  parameter int WORDS = 8,
  parameter int DW    = 32,
  parameter int AW    = 20,
  localparam int OW   = $clog2(WORDS),
  localparam int CW   = $clog2(WORDS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                miss_valid,
  input  logic [AW-1:0]       miss_line,
  input  logic [OW-1:0]       miss_offset,
  input  logic                miss_wrap,
  output logic                busy,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic [AW+OW-1:0]    mem_req_addr,
  input  logic                mem_rsp_valid,
  output logic                mem_rsp_ready,
  input  logic [DW-1:0]       mem_rsp_data,
  output logic                cpu_valid,
  output logic [DW-1:0]       cpu_data,
  output logic                fill_valid,
  output logic [AW-1:0]       fill_line_addr,
  output logic [WORDS*DW-1:0] fill_data
);
  import refill_pkg::*;

  logic          busy_q;
  logic [AW-1:0] line_q;
  logic [OW-1:0] off_q;
  fetch_order_e  order_q;
  logic          fill_q;

  logic          accept, req_fire, rsp_fire, last_rsp;
  logic [CW-1:0] req_beat, rsp_beat;
  logic [OW-1:0] req_idx, rsp_idx;
  logic          req_done, rsp_done;
  logic          fwd_done;

  assign accept   = miss_valid && !busy_q;
  assign req_fire = mem_req_valid && mem_req_ready;
  assign rsp_fire = mem_rsp_valid && mem_rsp_ready;
  assign last_rsp = rsp_fire && (rsp_beat == CW'(WORDS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      line_q  <= '0;
      off_q   <= '0;
      order_q <= ORDER_ASCENDING;
      fill_q  <= 1'b0;
    end else begin
      fill_q <= last_rsp;
      if (accept) begin
        busy_q  <= 1'b1;
        line_q  <= miss_line;
        off_q   <= miss_offset;
        order_q <= fetch_order_e'(miss_wrap);
      end else if (last_rsp) begin
        busy_q <= 1'b0;
      end
    end
  end

  refill_seq #(.WORDS(WORDS)) u_req_seq (
    .clk(clk), .rst(rst), .start(accept), .base_off(off_q), .order(order_q),
    .advance(req_fire), .beat(req_beat), .word_idx(req_idx), .done(req_done)
  );

  refill_seq #(.WORDS(WORDS)) u_rsp_seq (
    .clk(clk), .rst(rst), .start(accept), .base_off(off_q), .order(order_q),
    .advance(rsp_fire), .beat(rsp_beat), .word_idx(rsp_idx), .done(rsp_done)
  );

  refill_linebuf #(.WORDS(WORDS), .DW(DW)) u_linebuf (
    .clk(clk), .wr_en(rsp_fire), .wr_idx(rsp_idx), .wr_data(mem_rsp_data),
    .line_out(fill_data)
  );

  refill_fwd #(.WORDS(WORDS), .DW(DW)) u_fwd (
    .clk(clk), .rst(rst), .clear(accept), .rsp_fire(rsp_fire), .rsp_idx(rsp_idx),
    .want_idx(off_q), .rsp_data(mem_rsp_data), .cpu_valid(cpu_valid),
    .cpu_data(cpu_data), .fwd_done(fwd_done)
  );

  assign busy           = busy_q;
  assign mem_req_valid  = busy_q && !req_done;
  assign mem_req_addr   = {line_q, req_idx};
  assign mem_rsp_ready  = busy_q && !rsp_done && (rsp_beat < req_beat);
  assign fill_valid     = fill_q;
  assign fill_line_addr = line_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R5
  AST_BUSY_MISS_IGNORED: assert property (@(posedge clk) disable iff (rst)
    busy && miss_valid |=> $stable(line_q) && $stable(off_q)); // R2
  AST_WRAP_LEADS_WITH_MISS: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && order_q == ORDER_WRAPPED && req_beat == '0
    |-> mem_req_addr[OW-1:0] == off_q); // R3
  AST_RETURN_BEFORE_FILL: assert property (@(posedge clk) disable iff (rst)
    fill_valid |-> (fwd_done || cpu_valid)); // R6
  AST_IDLE_AT_FILL: assert property (@(posedge clk) disable iff (rst)
    fill_valid |-> !busy); // R9
  AST_FILL_PULSE: assert property (@(posedge clk) disable iff (rst)
    fill_valid |=> !fill_valid); // R8
endmodule

// File: tb/line_refill_ctrl_tb.sv
`timescale 1ns/1ps
module line_refill_ctrl_tb;
  localparam int WORDS = 8;
  localparam int DW = 32;
  localparam int AW = 20;
  localparam int OW = 3;

  logic clk = 0;
  logic rst = 1;
  logic miss_valid = 0;
  logic [AW-1:0] miss_line = '0;
  logic [OW-1:0] miss_offset = '0;
  logic miss_wrap = 0;
  logic busy, mem_req_valid, mem_rsp_ready, cpu_valid, fill_valid;
  logic mem_req_ready = 0;
  logic mem_rsp_valid = 0;
  logic [DW-1:0] mem_rsp_data = '0;
  logic [AW+OW-1:0] mem_req_addr;
  logic [DW-1:0] cpu_data;
  logic [AW-1:0] fill_line_addr;
  logic [WORDS*DW-1:0] fill_data;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  line_refill_ctrl #(.WORDS(WORDS), .DW(DW), .AW(AW)) u_dut (
    .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_line(miss_line),
    .miss_offset(miss_offset), .miss_wrap(miss_wrap), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .cpu_valid(cpu_valid), .cpu_data(cpu_data), .fill_valid(fill_valid),
    .fill_line_addr(fill_line_addr), .fill_data(fill_data)
  );

  function automatic logic [DW-1:0] word_of(input logic [AW-1:0] ln, input int idx);
    return (32'(ln) * 32'h9E3779B1) ^ (32'(idx) << 20) ^ 32'(idx);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_miss(input logic [AW-1:0] ln, input int off, input bit wrap,
                          input int lat_max, input bit junk);
    int nreq = 0;
    int nrsp = 0;
    int qidx[8];
    int wait_c;
    int cpu_seen = 0;
    int cyc = 0;
    bit exp_cpu = 0;
    bit exp_fill = 0;
    bit done = 0;
    bit prev_stall = 0;
    logic [AW+OW-1:0] prev_addr = '0;
    miss_valid = 1; miss_line = ln; miss_offset = OW'(off); miss_wrap = wrap;
    @(negedge clk);
    miss_valid = 0;
    chk(busy == 1'b1, "R2 busy after accept", longint'(busy), 1);
    wait_c = $urandom_range(lat_max, 0);
    while (!done && cyc < 400) begin
      chk(cpu_valid == exp_cpu, "R6 return timing", longint'(cpu_valid), longint'(exp_cpu));
      if (cpu_valid) begin
        cpu_seen++;
        chk(cpu_data == word_of(ln, off), "R6 return data", longint'(cpu_data), longint'(word_of(ln, off)));
        if (wrap) chk(nrsp == 1, "R7 restart after first response", nrsp, 1);
      end
      chk(fill_valid == exp_fill, "R8 fill timing", longint'(fill_valid), longint'(exp_fill));
      if (exp_fill) begin
        chk(fill_line_addr == ln, "R8 fill line", longint'(fill_line_addr), longint'(ln));
        for (int i = 0; i < WORDS; i++)
          chk(fill_data[i*DW +: DW] == word_of(ln, i), "R8 fill word",
              longint'(fill_data[i*DW +: DW]), longint'(word_of(ln, i)));
        chk(busy == 1'b0, "R9 idle at fill", longint'(busy), 0);
        chk(cpu_seen == 1, "R6 one return per miss", cpu_seen, 1);
        done = 1;
      end
      if (!done) begin
        exp_cpu = 0;
        exp_fill = 0;
        chk(mem_req_valid == (nreq < WORDS), "R10 request count", longint'(mem_req_valid), longint'(nreq < WORDS));
        chk(mem_rsp_ready == (nrsp < nreq), "R10 response ready", longint'(mem_rsp_ready), longint'(nrsp < nreq));
        if (prev_stall)
          chk(mem_req_valid && mem_req_addr == prev_addr, "R5 stalled request held",
              longint'(mem_req_addr), longint'(prev_addr));
        // response side uses requests issued before this edge
        mem_rsp_valid = (nrsp < nreq) && (wait_c == 0);
        mem_rsp_data = (nrsp < nreq) ? word_of(ln, qidx[nrsp]) : 32'hDEAD_BEEF;
        if (mem_rsp_valid && mem_rsp_ready) begin
          exp_cpu = (qidx[nrsp] == off);
          exp_fill = (nrsp == WORDS - 1);
          nrsp++;
          wait_c = $urandom_range(lat_max, 0);
        end else if (nrsp < nreq && wait_c > 0) begin
          wait_c--;
        end
        mem_req_ready = (lat_max == 0) ? 1'b1 : 1'($urandom_range(1, 0));
        if (mem_req_valid) begin
          int exp_idx = wrap ? (off + nreq) % WORDS : nreq;
          if (mem_req_ready) begin
            chk(int'(mem_req_addr[OW-1:0]) == exp_idx, wrap ? "R3 wrapped order" : "R4 ascending order",
                longint'(mem_req_addr[OW-1:0]), exp_idx);
            chk(mem_req_addr[AW+OW-1:OW] == ln, "R5 request line", longint'(mem_req_addr[AW+OW-1:OW]), longint'(ln));
            qidx[nreq] = exp_idx;
            nreq++;
          end
        end
        prev_stall = mem_req_valid && !mem_req_ready;
        prev_addr = mem_req_addr;
        if (junk && !exp_fill && $urandom_range(1, 0) == 1) begin
          miss_valid = 1; miss_line = ~ln; miss_offset = OW'($urandom_range(7, 0)); miss_wrap = ~wrap;
        end else begin
          miss_valid = 0;
        end
        @(negedge clk);
        cyc++;
      end
    end
    if (!done) chk(0, "R8 fill never arrived", 0, 1);
    miss_valid = 0; mem_rsp_valid = 0; mem_req_ready = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rst = 0;
    chk(busy == 0, "R1 busy", longint'(busy), 0);
    chk(mem_req_valid == 0, "R1 req valid", longint'(mem_req_valid), 0);
    chk(mem_rsp_ready == 0, "R1 rsp ready", longint'(mem_rsp_ready), 0);
    chk(cpu_valid == 0, "R1 cpu valid", longint'(cpu_valid), 0);
    chk(fill_valid == 0, "R1 fill valid", longint'(fill_valid), 0);
    // directed corners: offset 0 and 7 in both orders, zero-stall memory
    run_miss(20'h00ABC, 0, 1'b1, 0, 0);
    run_miss(20'h00ABD, 7, 1'b1, 0, 0);
    run_miss(20'h00ABE, 0, 1'b0, 0, 0);
    run_miss(20'h00ABF, 7, 1'b0, 0, 1);
    @(negedge clk);
    // random misses, back-to-back and with gaps, random stalls
    for (int n = 0; n < 60; n++) begin
      run_miss(AW'($urandom), $urandom_range(7, 0), 1'($urandom_range(1, 0)),
               $urandom_range(4, 0), 1'($urandom_range(1, 0)));
      repeat ($urandom_range(2, 0)) @(negedge clk);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule